// File: doc/BRIEF.md
# Interval Timer with Interrupt Return-Address Hold

This block pairs an 8-bit index register with a periodic interrupt source, and adds a save and restore path for the program counter. The index register advances by one at every instruction boundary, so it doubles as a free-running interval timer. Software can still overwrite it at any time from the data bus. When the count wraps from its top value back to zero, the block raises an interrupt. Taking the interrupt stores the address of the next instruction in a hold register and forces the program counter to the vector address 0x0000. A return instruction then copies the hold register back into the program counter.

Reset leaves the block in the same state an interrupt would: the program counter sits at the vector and the hold register is cleared. Only the program counter is saved. Software must preserve every other register. While an interrupt is being serviced, further wraps of the timer are dropped until the return instruction completes. The return instruction therefore never has to deal with a nested save.

Top module: `xtimer_pcsave`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `x_q` is 0x00, `pc` is 0x0000 and `irq` is 0. The service flag and the hold register are clear.
- R2: A cycle with `step` high and `x_load` low increments `x_q` by one, modulo 256, at the next edge. With both `step` and `x_load` low, `x_q` does not change.
- R3: A cycle with `x_load` high puts `x_din` into `x_q` at the next edge, whether or not `step` is high. The load takes priority over the increment, and a load never counts as a wrap.
- R4: A wrap is a cycle with `step` high, `x_load` low and `x_q` equal to 0xFF. A wrap that is taken makes `irq` high for exactly the one cycle that follows it.
- R5: When an interrupt is taken, `pc` becomes 0x0000 at the same edge that raises `irq`. The hold register captures the old `pc` plus one, which is the address of the next instruction.
- R6: On a `step` cycle with no interrupt taken and no return, `pc` increments by one, modulo 65536. Without `step`, `pc` holds.
- R7: A cycle with both `step` and `reti` high loads `pc` from the hold register and clears the service flag.
- R8: A wrap that occurs while the service flag is set starts no interrupt. `irq` stays 0 and `pc` simply increments.
- R9: A wrap that falls on the same `step` cycle as `reti` starts no interrupt. The return takes effect, and `pc` equals the held address.
- R10: `reti` without `step` has no effect on `pc`, on `x_q` or on the service flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low, handled as an interrupt to the vector |
| x_load | input | 1 | Load `x_din` into the timer register |
| x_din | input | 8 | Data bus value for the timer register |
| step | input | 1 | Instruction boundary strobe |
| reti | input | 1 | Return-from-interrupt decode, valid together with `step` |
| x_q | output | 8 | Timer/index register value |
| irq | output | 1 | One-cycle interrupt pulse |
| pc | output | 16 | Program counter |

## Verification
Two pairs of functions can land on the same edge. A timer wrap can coincide with a return instruction, and a wrap can also coincide with a load of the timer register. The bench provokes the first pair by loading 0xFF into the timer and then issuing a step with `reti` high. It judges the result by checking that `irq` stays low while `pc` takes the held address. It provokes the second pair by issuing a step together with a load while the timer holds 0xFF, and checks that the loaded value appears with no interrupt and no vector jump.

// File: rtl/xtimer_pcsave.sv
module xtimer_pcsave #(
  parameter int XW  = 8,
  parameter int PCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           x_load,
  input  logic [XW-1:0]  x_din,
  input  logic           step,
  input  logic           reti,
  output logic [XW-1:0]  x_q,
  output logic           irq,
  output logic [PCW-1:0] pc
);

  localparam logic [XW-1:0] XTOP = {XW{1'b1}};

  logic [PCW-1:0] hold;
  logic           in_svc;
  logic           ret_go, wrap, take;

  assign ret_go = step & reti;
  assign wrap   = step & ~x_load & (x_q == XTOP);
  assign take   = wrap & ~in_svc & ~ret_go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q    <= '0;
      pc     <= '0;
      hold   <= '0;
      in_svc <= 1'b0;
      irq    <= 1'b0;
    end else begin
      irq <= take;
      if (x_load)    x_q <= x_din;
      else if (step) x_q <= x_q + 1'b1;
      if (take) begin
        hold   <= pc + 1'b1;
        pc     <= '0;
        in_svc <= 1'b1;
      end else if (ret_go) begin
        pc     <= hold;
        in_svc <= 1'b0;
      end else if (step) begin
        pc <= pc + 1'b1;
      end
    end
  end

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);                                              // R4
  AST_IRQ_AT_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pc == '0));                                        // R5
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    x_load |=> (x_q == $past(x_din)));                          // R3
  AST_STEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !x_load) |=> (x_q == $past(x_q) + 1'b1));          // R2
  AST_NO_NESTING: assert property (@(posedge clk) disable iff (!rst_n)
    (in_svc && !ret_go) |=> !irq);                              // R8
  AST_RETURN_PC: assert property (@(posedge clk) disable iff (!rst_n)
    ret_go |=> (pc == $past(hold) && !irq));                    // R7 R9
  AST_RETI_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !step && !x_load) |=> $stable(pc) && $stable(x_q)); // R10

endmodule

// File: tb/sim_xtimer_pcsave.sv
module sim_xtimer_pcsave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        x_load = 1'b0;
  logic [7:0]  x_din = '0;
  logic        step = 1'b0;
  logic        reti = 1'b0;
  logic [7:0]  x_q;
  logic        irq;
  logic [15:0] pc;

  always #2.5 clk = ~clk;

  xtimer_pcsave u0 (.clk(clk), .rst_n(rst_n), .x_load(x_load), .x_din(x_din),
                    .step(step), .reti(reti), .x_q(x_q), .irq(irq), .pc(pc));

  logic [24:0] qv[$];
  string       qt[$];
  int          n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;

  logic [7:0]  mx = '0;
  logic [15:0] mpc = '0, mhold = '0;
  logic        msvc = 1'b0, mirq = 1'b0;

  task automatic cyc(input logic r, input logic ld, input logic [7:0] d,
                     input logic st, input logic rt, input string tag);
    logic wrap, take, ret;
    @(negedge clk);
    rst_n = r; x_load = ld; x_din = d; step = st; reti = rt;
    if (!r) begin
      mx = '0; mpc = '0; mhold = '0; msvc = 1'b0; mirq = 1'b0;
    end else begin
      ret  = st & rt;
      wrap = st & ~ld & (mx == 8'hFF);
      take = wrap & ~msvc & ~ret;
      mirq = take;
      if (ld) mx = d; else if (st) mx = mx + 8'd1;
      if (take) begin mhold = mpc + 16'd1; mpc = '0; msvc = 1'b1; end
      else if (ret) begin mpc = mhold; msvc = 1'b0; end
      else if (st) mpc = mpc + 16'd1;
    end
    qv.push_back({mx, mirq, mpc});
    qt.push_back(tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (qv.size() > 0) begin
      logic [24:0] e;
      string t;
      e = qv.pop_front();
      t = qt.pop_front();
      n_cmp++;
      if ({x_q, irq, pc} !== e) begin
        n_bad++;
        $display("FAIL %s: got x=%h irq=%b pc=%h expected x=%h irq=%b pc=%h",
                 t, x_q, irq, pc, e[24:17], e[16], e[15:0]);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(0, 0, 8'h00, 0, 0, "R1 reset");
    cyc(0, 1, 8'h55, 1, 1, "R1 reset ignores inputs");
    cyc(1, 0, 8'h00, 0, 0, "R1 first cycle / R2 R6 idle hold");
    for (int i = 0; i < 5; i++) cyc(1, 0, 8'h00, 1, 0, "R2 R6 step count");
    cyc(1, 0, 8'h00, 0, 1, "R10 reti without step");
    cyc(1, 1, 8'hFD, 1, 0, "R3 load with step");
    cyc(1, 1, 8'h10, 0, 0, "R3 load without step");
    cyc(1, 1, 8'hFE, 0, 0, "R3 load");
    cyc(1, 0, 8'h00, 1, 0, "R2 step to FF");
    cyc(1, 0, 8'h00, 1, 0, "R4 R5 wrap takes interrupt");
    cyc(1, 0, 8'h00, 0, 0, "R4 irq one cycle");
    for (int i = 0; i < 3; i++) cyc(1, 0, 8'h00, 1, 0, "R6 handler steps");
    cyc(1, 1, 8'hFF, 0, 0, "R3 preload FF");
    cyc(1, 0, 8'h00, 1, 0, "R8 wrap in service ignored");
    cyc(1, 0, 8'h00, 0, 1, "R10 reti idle in service");
    cyc(1, 0, 8'h00, 1, 1, "R7 return restores pc");
    cyc(1, 1, 8'hFF, 0, 0, "R3 preload FF");
    cyc(1, 1, 8'h20, 1, 0, "R3 load beats wrap");
    cyc(1, 0, 8'h00, 0, 0, "R3 no irq after load");
    cyc(1, 1, 8'hFF, 0, 0, "R3 preload FF");
    cyc(1, 0, 8'h00, 1, 0, "R4 R5 second interrupt");
    cyc(1, 0, 8'h00, 1, 0, "R4 irq drops");
    cyc(1, 1, 8'hFF, 0, 0, "R3 preload FF");
    cyc(1, 0, 8'h00, 1, 1, "R9 wrap with reti");
    cyc(1, 0, 8'h00, 0, 0, "R9 no late irq");
    cyc(1, 1, 8'hFF, 0, 0, "R3 preload FF");
    cyc(1, 0, 8'h00, 1, 1, "R9 wrap with reti, not in service");
    cyc(1, 1, 8'hFF, 0, 0, "R3 preload FF");
    cyc(1, 0, 8'h00, 1, 0, "R4 wrap after return fires");
    cyc(1, 0, 8'h00, 1, 0, "R6 step in handler");
    cyc(0, 0, 8'h00, 1, 0, "R1 reset mid-run");
    cyc(1, 0, 8'h00, 1, 1, "R1 R7 return after reset uses cleared hold");
    cyc(1, 0, 8'h00, 0, 0, "R1 settle");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule